// File: doc/BRIEF.md
# Serial Receive Conditioner with Baud Measurement

This block sits between the receive pin of an asynchronous serial port and the receiver that shifts in data bits. It picks the line source: the external pin, or the local transmit line when loopback is on. It can invert the line so that a port idling low looks like one idling high. It then brings the result into the core clock domain through a flop chain. Every later function works on this single clean, positive-polarity bit stream.

Two self-clearing helpers run on top of that stream. The wake helper is armed by a request pulse. It raises a one-cycle interrupt on the first falling edge it sees, and it disarms on the rising edge that follows. The baud helper is also armed by a request pulse. It times the next character, which must be the alternating sync value 0x55, and it turns the time between the first and the fifth falling edge into a baud-generator divisor for either 16x or 4x oversampling. If its counter runs out first, it raises a sticky overflow flag and keeps the old divisor.

A separate gate lets an infrared encoder/decoder enable through only in 16x mode. The whole block rests while the module enable is low.

Top module: `rx_front_end`

## Requirements
- R1: While `en` is low, `rx_bit` is held at 1, `wake_irq` and `div_done` stay low, both armed flags are cleared, and arm requests are not accepted.
- R2: With `inv_sel` = 1, the selected line is inverted before synchronization, so a line idling at 0 gives `rx_bit` = 1.
- R3: With `loop_sel` = 1, the line source is `tx_loc` and `rx_pin` is ignored; with `loop_sel` = 0 the source is `rx_pin`.
- R4: A change of the conditioned line appears on `rx_bit` after exactly two rising clock edges. After reset, `rx_bit` = 1, `div_out` = 0 and all flags are 0.
- R5: When `wake_armed` = 1, the first 1-to-0 transition of `rx_bit` raises `wake_irq` for exactly one cycle, starting one clock after `rx_bit` falls.
- R6: After that falling edge, `wake_armed` clears on the next 0-to-1 transition of `rx_bit`. A second falling edge raises no interrupt.
- R7: With `abd_armed` = 1, the block counts N cycles from a falling edge of `rx_bit` to the fourth falling edge after it. It then loads `div_out` = round(N / (8*OS)) - 1, clamped at 0, where OS = 16 when `hs_sel` = 0 at the start and OS = 4 when `hs_sel` = 1. At the same time it pulses `div_done` for one cycle, one clock after that edge reaches `rx_bit`, and clears `abd_armed`.
- R8: `ir_ok` = `ir_req` & `en` & ~`hs_sel`. The infrared request is ignored in 4x mode.
- R9: `div_out` changes only in a cycle where `div_done` is 1.
- R10: If the counter reaches its all-ones value before the final edge, the block sets `abd_ovf`, clears `abd_armed`, gives no `div_done` and leaves `div_out` unchanged. `abd_ovf` stays set until the next accepted `abd_set`, which clears it.
- R11: When wake and baud measurement are armed together, the same falling edge raises `wake_irq` and starts the measurement. The character then yields a normal divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Module enable |
| inv_sel | input | 1 | Invert the receive line (idle level 0) |
| loop_sel | input | 1 | Take the line from `tx_loc` instead of `rx_pin` |
| hs_sel | input | 1 | 1 = 4x oversampling, 0 = 16x |
| ir_req | input | 1 | Infrared encoder/decoder enable request |
| wake_set | input | 1 | One-cycle request that arms wake detection |
| abd_set | input | 1 | One-cycle request that arms baud measurement |
| rx_pin | input | 1 | External receive line (asynchronous) |
| tx_loc | input | 1 | Local transmit line for loopback |
| rx_bit | output | 1 | Conditioned, synchronized receive bit |
| ir_ok | output | 1 | Gated infrared enable |
| wake_armed | output | 1 | Wake detection armed (self-clearing) |
| wake_irq | output | 1 | One-cycle wake interrupt |
| abd_armed | output | 1 | Baud measurement armed (self-clearing) |
| div_out | output | DIVW | Last measured divisor |
| div_done | output | 1 | One-cycle divisor-loaded pulse |
| abd_ovf | output | 1 | Sticky measurement overflow |

## Verification
The assertions check, on every cycle, the properties that hold at all times:
- the rest state one cycle after `en` drops;
- the single-cycle width of the wake and done pulses;
- `abd_armed` is clear whenever `div_done` fires;
- `div_out` changes only under `div_done`;
- the overflow flag is sticky;
- the infrared gate in 4x mode.

Only the bench scenarios can show the rest:
- the actual divisor values, including the rounding in both oversampling modes;
- the two-edge latency of the line;
- the one-clock latency of each pulse after the falling edge;
- the wake helper disarming on a rising edge;
- the overflow path on a line held low;
- the shared edge when both helpers are armed.

// File: rtl/rxfe_pkg.sv
package rxfe_pkg;

   typedef enum logic [0:0] {
      MS_IDLE = 1'b0,
      MS_RUN  = 1'b1
   } meas_st_t;

   localparam int unsigned OS_STD      = 16;
   localparam int unsigned OS_FAST     = 4;
   localparam int unsigned SPAN_BITS   = 8;
   localparam int unsigned EDGES_AFTER = 4;

   localparam int unsigned SH_STD  = $clog2(SPAN_BITS * OS_STD);
   localparam int unsigned SH_FAST = $clog2(SPAN_BITS * OS_FAST);

endpackage

// File: rtl/rxfe_sync.sv
module rxfe_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("rxfe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
      end else if (!en) begin
         chain <= '1;
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rxfe_edge.sv
module rxfe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic lvl,
   output logic fall,
   output logic rise
);

   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b1;
      end else if (!en) begin
         prev <= 1'b1;
      end else begin
         prev <= lvl;
      end
   end

   assign fall = en & prev & ~lvl;
   assign rise = en & ~prev & lvl;

endmodule

// File: rtl/rxfe_wake.sv
module rxfe_wake (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic arm_req,
   input  logic fall,
   input  logic rise,
   output logic armed,
   output logic irq
);

   logic seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         seen  <= 1'b0;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (!en) begin
            armed <= 1'b0;
            seen  <= 1'b0;
         end else if (!armed) begin
            if (arm_req) begin
               armed <= 1'b1;
               seen  <= 1'b0;
            end
         end else if (fall && !seen) begin
            irq  <= 1'b1;
            seen <= 1'b1;
         end else if (rise && seen) begin
            armed <= 1'b0;
            seen  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/rxfe_baud.sv
module rxfe_baud
   import rxfe_pkg::*;
#(
   parameter int unsigned CNTW      = 20,
   parameter int unsigned DIVW      = 16,
   parameter bit          ROUND_DIV = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            arm_req,
   input  logic            hs_sel,
   input  logic            fall,
   output logic            armed,
   output logic [DIVW-1:0] div_q,
   output logic            done,
   output logic            ovf
);

   localparam int unsigned NFW = $clog2(EDGES_AFTER + 1);
   localparam logic [NFW-1:0] NF_LAST = NFW'(EDGES_AFTER - 1);

   generate
      if (CNTW < 8) begin : g_cnt_small
         $error("rxfe_baud: CNTW must be at least 8");
      end
      if (DIVW + SH_FAST < CNTW + 1) begin : g_div_narrow
         $error("rxfe_baud: DIVW too narrow for CNTW");
      end
   endgenerate

   meas_st_t        st;
   logic [CNTW-1:0] cnt;
   logic [NFW-1:0]  nf;
   logic            fast;

   // rounding bias, chosen at elaboration
   logic [CNTW:0] bias;
   generate
      if (ROUND_DIV) begin : g_round
         assign bias = fast ? (CNTW+1)'((SPAN_BITS * OS_FAST) / 2)
                            : (CNTW+1)'((SPAN_BITS * OS_STD) / 2);
      end else begin : g_trunc
         assign bias = '0;
      end
   endgenerate

   logic [CNTW:0]   sum;
   logic [CNTW:0]   quo;
   logic [DIVW-1:0] div_nxt;

   always_comb begin
      sum = {1'b0, cnt} + bias;
      quo = fast ? (sum >> SH_FAST) : (sum >> SH_STD);
      if (quo == '0) begin
         div_nxt = '0;
      end else begin
         div_nxt = DIVW'(quo - 1'b1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= MS_IDLE;
         armed <= 1'b0;
         cnt   <= '0;
         nf    <= '0;
         fast  <= 1'b0;
         div_q <= '0;
         done  <= 1'b0;
         ovf   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            st    <= MS_IDLE;
            armed <= 1'b0;
            cnt   <= '0;
            nf    <= '0;
         end else begin
            case (st)
               MS_IDLE: begin
                  if (armed && fall) begin
                     st   <= MS_RUN;
                     cnt  <= CNTW'(1);
                     nf   <= '0;
                     fast <= hs_sel;
                  end else if (arm_req) begin
                     armed <= 1'b1;
                     ovf   <= 1'b0;
                  end
               end
               MS_RUN: begin
                  if (fall && nf == NF_LAST) begin
                     st    <= MS_IDLE;
                     armed <= 1'b0;
                     done  <= 1'b1;
                     div_q <= div_nxt;
                  end else if (&cnt) begin
                     st    <= MS_IDLE;
                     armed <= 1'b0;
                     ovf   <= 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                     if (fall) begin
                        nf <= nf + 1'b1;
                     end
                  end
               end
               default: st <= MS_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/rx_front_end.sv
module rx_front_end #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNTW        = 20,
   parameter int unsigned DIVW        = 16,
   parameter bit          ROUND_DIV   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            inv_sel,
   input  logic            loop_sel,
   input  logic            hs_sel,
   input  logic            ir_req,
   input  logic            wake_set,
   input  logic            abd_set,
   input  logic            rx_pin,
   input  logic            tx_loc,
   output logic            rx_bit,
   output logic            ir_ok,
   output logic            wake_armed,
   output logic            wake_irq,
   output logic            abd_armed,
   output logic [DIVW-1:0] div_out,
   output logic            div_done,
   output logic            abd_ovf
);

   logic line_sel;
   logic line_pos;
   logic fall;
   logic rise;

   assign line_sel = loop_sel ? tx_loc : rx_pin;
   assign line_pos = line_sel ^ inv_sel;
   assign ir_ok    = ir_req & en & ~hs_sel;

   rxfe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .d     (line_pos),
      .q     (rx_bit)
   );

   rxfe_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .lvl   (rx_bit),
      .fall  (fall),
      .rise  (rise)
   );

   rxfe_wake u_wake (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .arm_req (wake_set),
      .fall    (fall),
      .rise    (rise),
      .armed   (wake_armed),
      .irq     (wake_irq)
   );

   rxfe_baud #(
      .CNTW      (CNTW),
      .DIVW      (DIVW),
      .ROUND_DIV (ROUND_DIV)
   ) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .arm_req (abd_set),
      .hs_sel  (hs_sel),
      .fall    (fall),
      .armed   (abd_armed),
      .div_q   (div_out),
      .done    (div_done),
      .ovf     (abd_ovf)
   );

endmodule

// File: rtl/rxfe_checker.sv
module rxfe_checker #(
   parameter int unsigned DIVW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            en,
   input logic            hs_sel,
   input logic            abd_set,
   input logic            rx_bit,
   input logic            ir_ok,
   input logic            wake_armed,
   input logic            wake_irq,
   input logic            abd_armed,
   input logic [DIVW-1:0] div_out,
   input logic            div_done,
   input logic            abd_ovf
);

   // R1: one cycle after en is low the block rests
   a_r1_rest_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (rx_bit && !wake_irq && !div_done && !wake_armed && !abd_armed));

   // R5: wake interrupt lasts a single cycle and only while armed
   a_r5_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |=> !wake_irq);

   a_r5_wake_armed: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> wake_armed);

   // R7: done pulse is single and the armed flag is already clear
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      div_done |=> !div_done);

   a_r7_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      div_done |-> !abd_armed);

   // R8: infrared gate in 4x mode
   a_r8_ir_gate: assert property (@(posedge clk) disable iff (!rst_n)
      hs_sel |-> !ir_ok);

   // R9: divisor moves only with done
   a_r9_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(div_out) |-> div_done);

   // R10: overflow flag is sticky until a new arm request
   a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(abd_ovf) && !$past(abd_set)) |-> abd_ovf);

endmodule

bind rx_front_end rxfe_checker #(.DIVW(DIVW)) u_chk (.*);

// File: tb/rx_front_end_bench.sv
module rx_front_end_bench;

   localparam int CLK_PER = 10;
   localparam int CNTW    = 12;
   localparam int DIVW    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, inv_sel = 1'b0, loop_sel = 1'b0, hs_sel = 1'b0, ir_req = 1'b0;
   logic wake_set = 1'b0, abd_set = 1'b0, rx_pin = 1'b1, tx_loc = 1'b1;
   logic rx_bit, ir_ok, wake_armed, wake_irq, abd_armed, div_done, abd_ovf;
   logic [DIVW-1:0] div_out;

   always #(CLK_PER/2) clk = ~clk;

   rx_front_end #(.SYNC_STAGES(2), .CNTW(CNTW), .DIVW(DIVW), .ROUND_DIV(1'b1)) u_rx_front_end (
      .clk(clk), .rst_n(rst_n), .en(en), .inv_sel(inv_sel), .loop_sel(loop_sel),
      .hs_sel(hs_sel), .ir_req(ir_req), .wake_set(wake_set), .abd_set(abd_set),
      .rx_pin(rx_pin), .tx_loc(tx_loc), .rx_bit(rx_bit), .ir_ok(ir_ok),
      .wake_armed(wake_armed), .wake_irq(wake_irq), .abd_armed(abd_armed),
      .div_out(div_out), .div_done(div_done), .abd_ovf(abd_ovf)
   );

   int n_cmp = 0, n_bad = 0;
   int cyc = 0, fall_cyc = 0, wake_cyc = 0, done_cyc = 0, n_wake = 0, n_done = 0;
   logic mon_prev = 1'b1;

   // event monitor, away from the active edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (mon_prev && !rx_bit) fall_cyc = cyc;
      mon_prev = rx_bit;
      if (wake_irq) begin n_wake = n_wake + 1; wake_cyc = cyc; end
      if (div_done) begin n_done = n_done + 1; done_cyc = cyc; end
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_wake();
      @(negedge clk) wake_set = 1'b1;
      @(negedge clk) wake_set = 1'b0;
   endtask

   task automatic pulse_abd();
      @(negedge clk) abd_set = 1'b1;
      @(negedge clk) abd_set = 1'b0;
   endtask

   // start, eight data bits LSB first, stop
   task automatic send_char(input logic [7:0] data, input int bt);
      logic [9:0] frame;
      frame = {1'b1, data, 1'b0};
      for (int i = 0; i < 10; i++) begin
         @(negedge clk) rx_pin = frame[i];
         idle(bt - 1);
      end
      idle(20);
   endtask

   task automatic t_reset();
      chk("R4 reset rx_bit", rx_bit, 1);
      chk("R4 reset div_out", div_out, 0);
      chk("R4 reset flags", {wake_armed, wake_irq, abd_armed, div_done, abd_ovf}, 0);
   endtask

   task automatic t_latency();
      @(negedge clk) rx_pin = 1'b0;
      @(negedge clk);
      chk("R4 one edge rx_bit", rx_bit, 1);
      @(negedge clk);
      chk("R4 two edges rx_bit", rx_bit, 0);
      @(negedge clk) rx_pin = 1'b1;
      idle(4);
   endtask

   task automatic t_invert();
      @(negedge clk) begin inv_sel = 1'b1; rx_pin = 1'b0; end
      idle(4);
      chk("R2 inverted idle 0", rx_bit, 1);
      @(negedge clk) rx_pin = 1'b1;
      idle(4);
      chk("R2 inverted high", rx_bit, 0);
      @(negedge clk) inv_sel = 1'b0;
      idle(4);
   endtask

   task automatic t_loop();
      @(negedge clk) begin loop_sel = 1'b1; tx_loc = 1'b0; rx_pin = 1'b1; end
      idle(4);
      chk("R3 loop tx low", rx_bit, 0);
      @(negedge clk) begin tx_loc = 1'b1; rx_pin = 1'b0; end
      idle(4);
      chk("R3 loop ignores pin", rx_bit, 1);
      @(negedge clk) begin loop_sel = 1'b0; end
      idle(4);
      chk("R3 pin source", rx_bit, 0);
      @(negedge clk) rx_pin = 1'b1;
      idle(4);
   endtask

   task automatic t_irda();
      @(negedge clk) begin ir_req = 1'b1; hs_sel = 1'b0; end
      @(negedge clk);
      chk("R8 ir in 16x", ir_ok, 1);
      @(negedge clk) hs_sel = 1'b1;
      @(negedge clk);
      chk("R8 ir ignored 4x", ir_ok, 0);
      @(negedge clk) begin ir_req = 1'b0; hs_sel = 1'b0; end
   endtask

   task automatic t_wake();
      int w0;
      w0 = n_wake;
      pulse_wake();
      idle(1);
      chk("R5 armed", wake_armed, 1);
      @(negedge clk) rx_pin = 1'b0;
      idle(6);
      chk("R5 irq count", n_wake - w0, 1);
      chk("R5 irq latency", wake_cyc - fall_cyc, 1);
      chk("R6 armed until rise", wake_armed, 1);
      @(negedge clk) rx_pin = 1'b1;
      idle(6);
      chk("R6 cleared on rise", wake_armed, 0);
      @(negedge clk) rx_pin = 1'b0;
      idle(6);
      chk("R6 no second irq", n_wake - w0, 1);
      @(negedge clk) rx_pin = 1'b1;
      idle(6);
   endtask

   task automatic t_baud(input int bt, input logic fast, input int expdiv, input string tag);
      int d0;
      d0 = n_done;
      @(negedge clk) hs_sel = fast;
      pulse_abd();
      idle(1);
      chk({tag, " armed"}, abd_armed, 1);
      send_char(8'h55, bt);
      chk({tag, " done count"}, n_done - d0, 1);
      chk({tag, " divisor"}, div_out, expdiv);
      chk({tag, " self clear"}, abd_armed, 0);
      chk({tag, " done latency"}, done_cyc - fall_cyc, 1);
      chk({tag, " no ovf"}, abd_ovf, 0);
      @(negedge clk) hs_sel = 1'b0;
   endtask

   task automatic t_hold();
      int d0;
      d0 = n_done;
      send_char(8'h55, 64);
      chk("R9 div held unarmed", div_out, 5);
      chk("R9 no done unarmed", n_done - d0, 0);
   endtask

   task automatic t_ovf();
      int d0;
      d0 = n_done;
      pulse_abd();
      @(negedge clk) rx_pin = 1'b0;
      idle(4300);
      @(negedge clk) rx_pin = 1'b1;
      idle(10);
      chk("R10 ovf set", abd_ovf, 1);
      chk("R10 disarmed", abd_armed, 0);
      chk("R10 div kept", div_out, 5);
      chk("R10 no done", n_done - d0, 0);
   endtask

   task automatic t_both();
      int w0, d0;
      w0 = n_wake; d0 = n_done;
      pulse_wake();
      pulse_abd();
      idle(1);
      chk("R10 ovf cleared by arm", abd_ovf, 0);
      send_char(8'h55, 64);
      chk("R11 wake irq", n_wake - w0, 1);
      chk("R11 done", n_done - d0, 1);
      chk("R11 divisor", div_out, 3);
      chk("R11 wake cleared", wake_armed, 0);
   endtask

   task automatic t_off();
      int w0, d0;
      w0 = n_wake; d0 = n_done;
      @(negedge clk) en = 1'b0;
      pulse_wake();
      pulse_abd();
      @(negedge clk) rx_pin = 1'b0;
      idle(5);
      chk("R1 rx_bit held", rx_bit, 1);
      chk("R1 arms refused", {wake_armed, abd_armed}, 0);
      @(negedge clk) rx_pin = 1'b1;
      send_char(8'h55, 64);
      chk("R1 no events", (n_wake - w0) + (n_done - d0), 0);
      chk("R1 div kept", div_out, 3);
   endtask

   initial begin
      #(CLK_PER * 150000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      @(negedge clk) begin rst_n = 1'b1; en = 1'b1; end
      idle(3);
      t_reset();
      t_latency();
      t_invert();
      t_loop();
      t_irda();
      t_wake();
      t_baud(64, 1'b0, 3, "R7 16x bt64");
      t_baud(70, 1'b1, 17, "R7 4x bt70");
      t_baud(100, 1'b0, 5, "R7 16x bt100");
      t_hold();
      t_ovf();
      t_both();
      t_off();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule